// File: doc/BRIEF.md
# Stop Mode Clock Controller

This block produces the bus clock for a small processor core and can stop it completely. Software writes two control registers through a simple write port. The first register holds a divider code that sets how far the main oscillator is divided to make the bus clock. The second register holds a stop bit. Writing 1 to the stop bit halts the bus clock at once and raises a stopped status.

While stopped, the block waits for the interrupt-pending line, which is assumed to carry only requests that are already enabled. A request clears the stop condition. A start-up wait then follows, timed by a counter that runs on the raw oscillator. After the wait the bus clock is supplied again. If the main oscillator is the selected source, the divider is forced to divide-by-8 on return. If the sub-clock is selected, the sub-clock drives the bus clock and the divider code is left as it was. A wake pulse, one bus clock period wide, tells the interrupt sequencer that execution can resume.

All logic runs on the main oscillator clock. The sub-clock is brought in through a synchronizer, and the bus clock leaves the block as a register output.

Top module: `stop_clock_ctrl`

## Requirements
- R1: After reset, stopped and wake_pulse are 0 and the divider code is 2. The bus clock therefore runs with a period of 8 oscillator cycles.
- R2: Writing code k (bits [1:0]) to address 0x0006 while the main source is selected gives a bus clock period of 2^(k+1) oscillator cycles: code 0 gives /2, 1 gives /4, 2 gives /8 and 3 gives /16.
- R3: Writing a 1 in bit 0 of address 0x0007 while running sets stopped from the next oscillator edge. bus_clk is 0 whenever stopped is 1.
- R4: A high irq_pending while stopped starts the start-up wait. stopped falls at the (WARM_CYCLES+1)-th oscillator edge, counting the edge that first samples the request.
- R5: When the main source is selected at the end of the wait, the divider code becomes 2 (/8) whatever its value before the stop.
- R6: When the sub-clock is selected at the end of the wait, the divider code keeps its value from before the stop.
- R7: wake_pulse rises together with the first rising bus_clk edge after the wait. It falls together with the next rising bus_clk edge, and it occurs once per wake-up.
- R8: While stopped is 1, which includes the start-up wait, writes to either register have no effect. Writing 0 to the stop bit does not end stop mode.
- R9: irq_pending has no effect while running: stopped and wake_pulse stay 0.
- R10: Writes to addresses other than 0x0006 and 0x0007 have no effect.
- R11: While running with the sub-clock selected, bus_clk follows the synchronized sub-clock. Its period equals the sub-clock period to within one oscillator cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Main oscillator clock; clocks all logic |
| clk_sub | input | 1 | Slow sub-clock, asynchronous to clk_osc |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_sub | input | 1 | 1 selects the sub-clock as the bus clock source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_pending | input | 1 | An enabled interrupt request is pending |
| bus_clk | output | 1 | Gated and divided bus clock |
| stopped | output | 1 | High during stop mode and the start-up wait |
| wake_pulse | output | 1 | One bus clock period wide, marks the resume |

## Verification
The divider is exercised with all four codes in directed order, and then with random codes mixed with random source selection at each stop. This separates the forced /8 return from the kept-code return, because a pre-stop code other than 2 gives a different period afterwards. Writes issued during stop mode and during the start-up wait, and writes to neighbouring addresses, are followed by a period measurement. Those writes leave a visible trace if they are wrongly accepted. Interrupt pulses given while running, and exact edge counting from the request to the fall of stopped, tell a correct wait length apart from one that is off by one or that wakes without a stop.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int DIV_W = 2;
  localparam logic [DIV_W-1:0] DIV_RESET = 2'd2;
  localparam logic [DIV_W-1:0] DIV_WAKE  = 2'd2;
  localparam int STOP_BIT = 0;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WARM = 2'd2
  } scc_state_e;
endpackage

// File: rtl/scc_sync.sv
module scc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[i] <= 1'b0;
          else        sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/scc_ctl_regs.sv
module scc_ctl_regs
  import scc_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int unsigned CTL0_ADDR = 6,
  parameter int unsigned CTL1_ADDR = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              accept,
  input  logic              force_div,
  output logic [DIV_W-1:0]  div_code,
  output logic              stop_req
);
  logic             hit0, hit1;
  logic             div_en;
  logic [DIV_W-1:0] div_q, div_d;
  logic             unused_bits;

  always_comb begin
    hit0     = wr_en && accept && (wr_addr == ADDR_W'(CTL0_ADDR));
    hit1     = wr_en && accept && (wr_addr == ADDR_W'(CTL1_ADDR));
    stop_req = hit1 && wr_data[STOP_BIT];
    div_en   = hit0 || force_div;
    div_d    = force_div ? DIV_WAKE : wr_data[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= DIV_RESET;
    else if (div_en) div_q <= div_d;
  end

  assign div_code    = div_q;
  assign unused_bits = ^wr_data[DATA_W-1:DIV_W];
endmodule

// File: rtl/scc_wake_seq.sv
module scc_wake_seq
  import scc_pkg::*;
#(
  parameter int WARM_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic irq_pending,
  output logic accept,
  output logic run_en,
  output logic warm_done,
  output logic stopped
);
  localparam int CNT_W = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_CYCLES - 1);

  scc_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    warm_done = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (stop_req) st_d = ST_STOP;
      end
      ST_STOP: begin
        if (irq_pending) begin
          st_d   = ST_WARM;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_WARM: begin
        if (cnt_q == WARM_LAST) begin
          st_d      = ST_RUN;
          warm_done = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign accept  = (st_q == ST_RUN);
  assign run_en  = (st_q == ST_RUN) && (st_d == ST_RUN);
  assign stopped = (st_q != ST_RUN);
endmodule

// File: rtl/scc_busclk_gen.sv
module scc_busclk_gen
  import scc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             sel_sub,
  input  logic             sub_level,
  input  logic [DIV_W-1:0] div_code,
  input  logic             wake_arm,
  output logic             bus_clk,
  output logic             wake_pulse
);
  localparam int MAX_HALF = 1 << ((1 << DIV_W) - 1);
  localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             bus_q, bus_d;
  logic             arm_q, arm_d;
  logic             wake_q, wake_d;
  logic             rise;

  always_comb begin
    lim   = CNT_W'((32'd1 << div_code) - 32'd1);
    bus_d = bus_q;
    cnt_d = cnt_q;
    if (!run_en) begin
      bus_d = 1'b0;
      cnt_d = '0;
    end else if (sel_sub) begin
      bus_d = sub_level;
      cnt_d = '0;
    end else if (cnt_q >= lim) begin
      bus_d = ~bus_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    rise   = run_en && bus_d && !bus_q;
    arm_d  = arm_q;
    wake_d = wake_q;
    if (!run_en) begin
      wake_d = 1'b0;
    end else if (rise) begin
      wake_d = arm_q;
      arm_d  = 1'b0;
    end
    if (wake_arm) arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bus_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bus_q <= bus_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      wake_q <= wake_d;
    end
  end

  assign bus_clk    = bus_q;
  assign wake_pulse = wake_q;
endmodule

// File: rtl/stop_clock_ctrl.sv
module stop_clock_ctrl
  import scc_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int unsigned CTL0_ADDR   = 6,
  parameter int unsigned CTL1_ADDR   = 7,
  parameter int          WARM_CYCLES = 256,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk_osc,
  input  logic              clk_sub,
  input  logic              rst_n,
  input  logic              sel_sub,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_pending,
  output logic              bus_clk,
  output logic              stopped,
  output logic              wake_pulse
);
  logic             rst_int_n;
  logic             sub_level;
  logic             accept, run_en, warm_done, stop_req, force_div;
  logic [DIV_W-1:0] div_code;

  scc_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk_osc), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  scc_sync #(.STAGES(SYNC_STAGES)) u_sub_sync (
    .clk(clk_osc), .rst_n(rst_int_n), .d(clk_sub), .q(sub_level)
  );

  assign force_div = warm_done && !sel_sub;

  scc_ctl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTL0_ADDR(CTL0_ADDR), .CTL1_ADDR(CTL1_ADDR)
  ) u_regs (
    .clk(clk_osc), .rst_n(rst_int_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .accept(accept), .force_div(force_div),
    .div_code(div_code), .stop_req(stop_req)
  );

  scc_wake_seq #(.WARM_CYCLES(WARM_CYCLES)) u_seq (
    .clk(clk_osc), .rst_n(rst_int_n),
    .stop_req(stop_req), .irq_pending(irq_pending),
    .accept(accept), .run_en(run_en),
    .warm_done(warm_done), .stopped(stopped)
  );

  scc_busclk_gen u_bus (
    .clk(clk_osc), .rst_n(rst_int_n),
    .run_en(run_en), .sel_sub(sel_sub), .sub_level(sub_level),
    .div_code(div_code), .wake_arm(warm_done),
    .bus_clk(bus_clk), .wake_pulse(wake_pulse)
  );
endmodule

// File: rtl/scc_checker.sv
module scc_checker
  import scc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stopped,
  input logic             bus_clk,
  input logic             wake_pulse,
  input logic             sel_sub,
  input logic [DIV_W-1:0] div_code
);
  logic stopped_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      stopped_q <= stopped;
      if (stopped_q && !stopped) pend_q <= 1'b1;
      else if (wake_pulse)       pend_q <= 1'b0;
    end
  end

  // R3
  bus_low_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !bus_clk);

  // R5
  main_wake_div8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stopped) && !$past(sel_sub)) |-> (div_code == DIV_WAKE));

  // R6
  sub_wake_keeps_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stopped) && $past(sel_sub)) |-> $stable(div_code));

  // R7
  wake_rise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pulse) |-> $rose(bus_clk));

  // R7
  wake_fall_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wake_pulse) && !stopped) |-> $rose(bus_clk));

  // R9
  wake_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_pulse) |-> pend_q);

  // R8
  regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && $past(stopped)) |-> $stable(div_code));
endmodule

bind stop_clock_ctrl scc_checker u_chk (
  .clk(clk_osc), .rst_n(rst_int_n), .stopped(stopped), .bus_clk(bus_clk),
  .wake_pulse(wake_pulse), .sel_sub(sel_sub), .div_code(div_code)
);

// File: tb/test_stop_clock_ctrl.sv
module test_stop_clock_ctrl;
  localparam int W = 256;
  localparam logic [15:0] A0 = 16'h0006;
  localparam logic [15:0] A1 = 16'h0007;

  logic clk_osc = 1'b0;
  logic clk_sub = 1'b0;
  logic rst_n = 1'b0;
  logic sel_sub = 1'b0;
  logic wr_en = 1'b0;
  logic irq_pending = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic bus_clk, stopped, wake_pulse;
  int checks = 0;
  int fails = 0;

  always #5 clk_osc = ~clk_osc;
  always #85 clk_sub = ~clk_sub;

  stop_clock_ctrl #(.WARM_CYCLES(W)) i_stop_clock_ctrl (
    .clk_osc(clk_osc), .clk_sub(clk_sub), .rst_n(rst_n), .sel_sub(sel_sub),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_pending(irq_pending), .bus_clk(bus_clk), .stopped(stopped),
    .wake_pulse(wake_pulse)
  );

  function automatic int exp_period(int code);
    return 2 << code;
  endfunction

  function automatic int exp_code_after(int prev, logic sub);
    return sub ? prev : 2;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk_osc);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_osc);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    logic pv;
    pv = bus_clk;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_osc);
      if (bus_clk && !pv) return;
      pv = bus_clk;
    end
  endtask

  task automatic meas(output int p);
    logic pv;
    wait_rise();
    p = 0;
    pv = bus_clk;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_osc);
      p++;
      if (bus_clk && !pv) return;
      pv = bus_clk;
    end
  endtask

  task automatic meas2(output int p);
    int t;
    meas(t);
    meas(p);
  endtask

  // Raises the request, counts edges until stopped falls; optional write during warm-up.
  task automatic wake_up(int warm_code, output int n);
    @(negedge clk_osc);
    irq_pending = 1'b1;
    n = 0;
    for (int i = 0; i < W + 100; i++) begin
      @(negedge clk_osc);
      n++;
      irq_pending = 1'b0;
      if (warm_code >= 0 && n == 5) begin
        wr_en = 1'b1; wr_addr = A0; wr_data = 8'(warm_code);
      end else if (n == 6) begin
        wr_en = 1'b0;
      end
      if (!stopped) return;
    end
  endtask

  task automatic check_wake(int exp_len);
    logic pv;
    int n;
    pv = bus_clk;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_osc);
      if (wake_pulse) break;
      pv = bus_clk;
    end
    chk(wake_pulse && bus_clk && !pv, "R7 wake rises with bus_clk", int'(bus_clk), 1);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      pv = bus_clk;
      @(negedge clk_osc);
      n++;
      if (!wake_pulse) break;
    end
    chk(bus_clk && !pv, "R7 wake falls with next bus_clk rise", int'(bus_clk), 1);
    if (exp_len > 0) chk(n == exp_len, "R5 wake width in /8 mode", n, exp_len);
    n = 0;
    repeat (40) begin
      @(negedge clk_osc);
      if (wake_pulse) n++;
    end
    chk(n == 0, "R7 single wake pulse", n, 0);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int p, n, code, hi;
    logic sub;
    void'($urandom(32'd20251));

    repeat (3) @(negedge clk_osc);
    chk(!stopped && !wake_pulse && !bus_clk, "R1 outputs in reset",
        int'({stopped, wake_pulse, bus_clk}), 0);
    repeat (2) @(negedge clk_osc);
    rst_n = 1'b1;
    repeat (10) @(negedge clk_osc);
    chk(!stopped && !wake_pulse, "R1 idle after reset", int'({stopped, wake_pulse}), 0);
    meas2(p);
    chk(p == exp_period(2), "R1 reset divider /8", p, exp_period(2));

    // R2: every divider code
    for (int k = 0; k < 4; k++) begin
      wr(A0, 8'(k));
      meas2(p);
      chk(p == exp_period(k), "R2 divider period", p, exp_period(k));
    end

    // R10: neighbouring addresses ignored
    wr(16'h0008, 8'h00);
    wr(16'h0005, 8'h01);
    wr(16'h0106, 8'h00);
    meas2(p);
    chk(p == exp_period(3), "R10 other address ignored", p, exp_period(3));

    // R3: enter stop
    wr(A0, 8'd0);
    wr(A1, 8'h01);
    chk(stopped && !bus_clk, "R3 stop entered", int'({stopped, bus_clk}), 2);
    hi = 0;
    repeat (20) begin
      @(negedge clk_osc);
      if (bus_clk) hi++;
    end
    chk(hi == 0, "R3 bus_clk held low", hi, 0);

    // R8: writes ignored in stop, writing 0 to stop bit does not wake
    wr(A0, 8'd3);
    wr(A1, 8'h00);
    repeat (5) @(negedge clk_osc);
    chk(stopped == 1'b1, "R8 stop bit write 0 ignored", int'(stopped), 1);

    // R4: start-up wait length, then R5/R7 wake on main source
    wake_up(1, n);
    chk(n == W + 1, "R4 start-up wait edges", n, W + 1);
    check_wake(8);
    meas2(p);
    chk(p == exp_period(2), "R5 forced /8 after main wake", p, exp_period(2));

    // R6/R8/R11: wake on sub-clock, divider kept, warm-up write ignored
    wr(A0, 8'd0);
    sel_sub = 1'b1;
    repeat (40) @(negedge clk_osc);
    meas2(p);
    chk(p >= 16 && p <= 18, "R11 sub-clock period", p, 17);
    wr(A1, 8'h01);
    chk(stopped == 1'b1, "R3 stop from sub source", int'(stopped), 1);
    wake_up(3, n);
    chk(n == W + 1, "R4 start-up wait edges (sub)", n, W + 1);
    check_wake(-1);
    sel_sub = 1'b0;
    repeat (20) @(negedge clk_osc);
    meas2(p);
    chk(p == exp_period(0), "R6 divider kept after sub wake (R8 warm write ignored)",
        p, exp_period(0));

    // R9: interrupt while running
    hi = 0;
    @(negedge clk_osc);
    irq_pending = 1'b1;
    repeat (10) @(negedge clk_osc);
    irq_pending = 1'b0;
    repeat (60) begin
      @(negedge clk_osc);
      if (stopped || wake_pulse) hi++;
    end
    chk(hi == 0, "R9 irq ignored while running", hi, 0);

    // Random mix
    for (int it = 0; it < 10; it++) begin
      code = $urandom_range(0, 3);
      sub  = 1'($urandom_range(0, 1));
      wr(A0, 8'(code));
      meas2(p);
      chk(p == exp_period(code), "R2 random divider", p, exp_period(code));
      sel_sub = sub;
      repeat (30) @(negedge clk_osc);
      wr(A1, 8'h01);
      chk(stopped && !bus_clk, "R3 random stop", int'({stopped, bus_clk}), 2);
      wake_up(-1, n);
      chk(n == W + 1, "R4 random wait", n, W + 1);
      check_wake(sub ? -1 : 8);
      sel_sub = 1'b0;
      repeat (20) @(negedge clk_osc);
      meas2(p);
      chk(p == exp_period(exp_code_after(code, sub)), "R5/R6 random return divider",
          p, exp_period(exp_code_after(code, sub)));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule